// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block holds an 8-bit condition code register and rewrites its negative, zero, overflow and carry bits after each arithmetic, shift or test operation. An execution unit presents the operation class, an operand size select (narrow or wide), both operands and the result, then pulses the update strobe. The block derives the new flags from those values and writes them one cycle later. Each class changes only the flags it owns, and the others keep their old values.

A direct load port replaces the whole register, for example when the register is restored from memory. The four upper bits (interrupt mask, half carry, extended mask and stop disable) are stored and can be loaded, but the update path never changes them. The register value and the four arithmetic flags are available as outputs. The result datapath itself is not part of this block.

Bit positions within the register are fixed: carry bit 0, overflow bit 1, zero bit 2, negative bit 3, interrupt mask bit 4, half carry bit 5, extended mask bit 6, stop disable bit 7. Class encoding on `op_cls`: 0 add, 1 subtract, 2 shift, 3 test. `wide_sel` 0 selects the narrow size (bits 7:0, top bit 7), 1 the wide size (bits 15:0, top bit 15).

Top module: `ccu_top`

## Requirements
- R1: A cycle with `rst_n` low at a clock edge leaves the register at 0x10 after that edge: interrupt mask set, all other bits clear.
- R2: With `ld_en` high, the register takes `ld_val` whole at the next edge.
- R3: When `ld_en` and `upd_en` are both high, the load takes effect and the update is discarded.
- R4: On an add update, carry is the top bit of (a&b)|(b&~r)|(a&~r) and overflow is the top bit of (a&b&~r)|(~a&~b&r), at the selected size.
- R5: On a subtract update, carry acts as a borrow and is the top bit of (~a&b)|(b&r)|(~a&r), and overflow is the top bit of (a&~b&~r)|(~a&b&r).
- R6: On every update, negative is the top bit of r at the selected size and zero is set only when r is all zeros at that size. Operand and result bits above bit 7 have no effect in narrow mode.
- R7: On a shift update, negative and zero come from r, overflow becomes the new negative XOR the carry held before the edge, and carry is unchanged.
- R8: On a test update, overflow is cleared, negative and zero come from r, and carry is unchanged.
- R9: The update path never changes register bits 7:4.
- R10: With neither `ld_en` nor `upd_en` high, the register holds its value.
- R11: `flag_c`, `flag_v`, `flag_z` and `flag_n` equal register bits 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Update strobe for the flag rules |
| op_cls | input | 2 | Operation class: 0 add, 1 subtract, 2 shift, 3 test |
| wide_sel | input | 1 | 0 narrow (8-bit), 1 wide (16-bit) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | Result of the operation |
| ld_en | input | 1 | Direct load strobe |
| ld_val | input | 8 | Value for a direct load |
| ccr_q | output | 8 | Register value |
| flag_c | output | 1 | Carry / borrow |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |

## Verification
The bench builds the block with its default widths, a 16-bit wide size and an 8-bit narrow size. This lets it cover both top-bit positions in one build. In narrow mode it drives junk in bits 15:8 to show those bits are masked off. It also makes results that are zero only in the low byte, and narrow carries that would set bit 8 of a wider sum.

// File: rtl/ccu_pkg.sv
// Package: shared class encoding, register bit positions and flag bundles
// for the condition code update unit. Assumes an 8-bit register.
package ccu_pkg;

    localparam int CCR_W = 8;

    // Register bit positions; software decodes these, so they are fixed.
    localparam int BIT_C = 0;
    localparam int BIT_V = 1;
    localparam int BIT_Z = 2;
    localparam int BIT_N = 3;
    localparam int BIT_I = 4;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'h10;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_TEST  = 2'd3
    } ccu_cls_e;

    // Candidate flags produced for one operand size.
    typedef struct packed {
        logic n;
        logic z;
        logic add_c;
        logic add_v;
        logic sub_c;
        logic sub_v;
    } ccu_size_flags_t;

    // Four arithmetic flags ordered n, z, v, c.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccu_nzvc_t;

endpackage

// File: rtl/ccu_size_flags.sv
// Module: ccu_size_flags
// Works out the candidate flags for one operand width W from a, b and r.
// Assumes r is the result of the operation the caller means; no arithmetic
// is redone here. Purely combinational.
module ccu_size_flags
    import ccu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    r,
    output ccu_size_flags_t flags
);

    localparam int MSB = W - 1;

    logic [W-1:0] add_cy_vec;
    logic [W-1:0] add_ov_vec;
    logic [W-1:0] sub_bw_vec;
    logic [W-1:0] sub_ov_vec;

    // Bitwise carry, overflow and borrow terms; only the top bit is used.
    always_comb begin
        add_cy_vec = (a & b) | (b & ~r) | (a & ~r);
        add_ov_vec = (a & b & ~r) | (~a & ~b & r);
        sub_bw_vec = (~a & b) | (b & r) | (~a & r);
        sub_ov_vec = (a & ~b & ~r) | (~a & b & r);
    end

    // Pack the candidates for the class selector.
    always_comb begin
        flags.n     = r[MSB];
        flags.z     = (r == '0);
        flags.add_c = add_cy_vec[MSB];
        flags.add_v = add_ov_vec[MSB];
        flags.sub_c = sub_bw_vec[MSB];
        flags.sub_v = sub_ov_vec[MSB];
    end

endmodule

// File: rtl/ccu_flag_select.sv
// Module: ccu_flag_select
// Picks the size, then applies the class rule to give new flag values and a
// per-flag write mask. Assumes cur_c is the carry held in the register now.
// Purely combinational.
module ccu_flag_select
    import ccu_pkg::*;
(
    input  ccu_cls_e        cls,
    input  logic            wide_sel,
    input  ccu_size_flags_t narrow_f,
    input  ccu_size_flags_t wide_f,
    input  logic            cur_c,
    output ccu_nzvc_t       new_val,
    output ccu_nzvc_t       new_mask
);

    ccu_size_flags_t sel_f;

    // Choose the candidate set for the selected operand size.
    always_comb begin
        sel_f = wide_sel ? wide_f : narrow_f;
    end

    // Apply the class rule; carry is masked off for shift and test.
    always_comb begin
        new_val.n = sel_f.n;
        new_val.z = sel_f.z;
        new_val.v = 1'b0;
        new_val.c = cur_c;
        new_mask  = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
        unique case (cls)
            CLS_ADD: begin
                new_val.v  = sel_f.add_v;
                new_val.c  = sel_f.add_c;
                new_mask.c = 1'b1;
            end
            CLS_SUB: begin
                new_val.v  = sel_f.sub_v;
                new_val.c  = sel_f.sub_c;
                new_mask.c = 1'b1;
            end
            CLS_SHIFT: begin
                new_val.v = sel_f.n ^ cur_c;
            end
            CLS_TEST: begin
                new_val.v = 1'b0;
            end
            default: begin
                new_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/ccu_reg.sv
// Module: ccu_reg
// The condition code register. A direct load takes priority over a masked
// flag update. Synchronous active-low reset sets the interrupt mask only.
// Assumes the update path only reaches bits 3:0.
module ccu_reg
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CCR_W-1:0] ld_val,
    input  logic             upd_en,
    input  ccu_nzvc_t        upd_val,
    input  ccu_nzvc_t        upd_mask,
    output logic [CCR_W-1:0] ccr_q
);

    logic [CCR_W-1:0] ccr_d;
    logic [CCR_W-1:0] upd_merged;

    // Merge the masked flags into the current value; upper bits pass through.
    always_comb begin
        upd_merged        = ccr_q;
        upd_merged[BIT_N] = upd_mask.n ? upd_val.n : ccr_q[BIT_N];
        upd_merged[BIT_Z] = upd_mask.z ? upd_val.z : ccr_q[BIT_Z];
        upd_merged[BIT_V] = upd_mask.v ? upd_val.v : ccr_q[BIT_V];
        upd_merged[BIT_C] = upd_mask.c ? upd_val.c : ccr_q[BIT_C];
    end

    // Next-state priority: load, then update, then hold.
    always_comb begin
        if (ld_en) begin
            ccr_d = ld_val;
        end else if (upd_en) begin
            ccr_d = upd_merged;
        end else begin
            ccr_d = ccr_q;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q <= CCR_RESET;
        end else begin
            ccr_q <= ccr_d;
        end
    end

endmodule

// File: rtl/ccu_top.sv
// Module: ccu_top
// Condition code flag update unit. Builds one flag generator per operand
// size, selects by class and size, and keeps the result in the register.
// Assumes NARROW_W <= DATA_W and that res comes from the same operation.
module ccu_top
    import ccu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_cls,
    input  logic              wide_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    input  logic              ld_en,
    input  logic [CCR_W-1:0]  ld_val,
    output logic [CCR_W-1:0]  ccr_q,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_n
);

    localparam int N_SIZES = 2;

    ccu_size_flags_t size_f [N_SIZES];
    ccu_nzvc_t       upd_val;
    ccu_nzvc_t       upd_mask;
    ccu_cls_e        cls;

    // Give the raw class code its enum type.
    always_comb begin
        cls = ccu_cls_e'(op_cls);
    end

    // One flag generator per operand size: index 0 narrow, index 1 wide.
    for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_size
        localparam int W = (gi == 0) ? NARROW_W : DATA_W;
        ccu_size_flags #(.W(W)) u_flags (
            .a     (opa[W-1:0]),
            .b     (opb[W-1:0]),
            .r     (res[W-1:0]),
            .flags (size_f[gi])
        );
    end

    ccu_flag_select u_sel (
        .cls      (cls),
        .wide_sel (wide_sel),
        .narrow_f (size_f[0]),
        .wide_f   (size_f[1]),
        .cur_c    (ccr_q[BIT_C]),
        .new_val  (upd_val),
        .new_mask (upd_mask)
    );

    ccu_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .upd_en   (upd_en),
        .upd_val  (upd_val),
        .upd_mask (upd_mask),
        .ccr_q    (ccr_q)
    );

    // Individual flag outputs.
    always_comb begin
        flag_c = ccr_q[BIT_C];
        flag_v = ccr_q[BIT_V];
        flag_z = ccr_q[BIT_Z];
        flag_n = ccr_q[BIT_N];
    end

endmodule

// File: rtl/ccu_chk.sv
// Module: ccu_chk
// Checker for ccu_top: priority, hold and per-class rules seen at the ports.
module ccu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_en,
    input logic [1:0] op_cls,
    input logic       ld_en,
    input logic [7:0] ld_val,
    input logic [7:0] ccr_q
);

    // R1: reset value
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> ccr_q == 8'h10);

    // R2 and R3: load is taken whole, even with an update
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ccr_q == $past(ld_val));

    // R10: no strobe means no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !upd_en) |=> $stable(ccr_q));

    // R9: update never touches the upper nibble
    a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en) |=> ccr_q[7:4] == $past(ccr_q[7:4]));

    // R7: shift keeps carry, overflow is N xor old carry
    a_r7_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && op_cls == 2'd2) |=> ccr_q[0] == $past(ccr_q[0]));
    a_r7_shift_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && op_cls == 2'd2) |=> ccr_q[1] == (ccr_q[3] ^ $past(ccr_q[0])));

    // R8: test clears overflow and keeps carry
    a_r8_test_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && op_cls == 2'd3) |=> (!ccr_q[1] && ccr_q[0] == $past(ccr_q[0])));

endmodule

bind ccu_top ccu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .op_cls (op_cls),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .ccr_q  (ccr_q)
);

// File: tb/ccu_top_tb.sv
`timescale 1ns/1ps
// Bench for ccu_top: a behavioural reference model advanced on every edge
// and compared with all outputs at every falling edge.
module ccu_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        upd_en;
    logic [1:0]  op_cls;
    logic        wide_sel;
    logic [15:0] opa, opb, res;
    logic        ld_en;
    logic [7:0]  ld_val;
    logic [7:0]  ccr_q;
    logic        flag_c, flag_v, flag_z, flag_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    logic [7:0] exp_ccr = 8'h00;

    always #4 clk = ~clk;

    ccu_top u_dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
        .wide_sel(wide_sel), .opa(opa), .opb(opb), .res(res),
        .ld_en(ld_en), .ld_val(ld_val), .ccr_q(ccr_q),
        .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
    );

    // Reference: next register value from the requirement rules.
    function automatic logic [7:0] model(logic [7:0] cur, bit rst, bit ld,
                                         logic [7:0] lv, bit up, int cls,
                                         bit wide, int a, int b, int r);
        int m  = wide ? 32'hFFFF : 32'hFF;
        int sb = wide ? 32'h8000 : 32'h80;
        int aa = a & m;
        int bb = b & m;
        int rr = r & m;
        bit n = (rr & sb) != 0;
        bit z = (rr == 0);
        bit c = cur[0];
        bit v = cur[1];
        if (rst) return 8'h10;
        if (ld)  return lv;
        if (!up) return cur;
        case (cls)
            0: begin
                c = (aa + bb) > m;
                v = ((aa & sb) == (bb & sb)) && ((rr & sb) != (aa & sb));
            end
            1: begin
                c = bb > aa;
                v = ((aa & sb) != (bb & sb)) && ((rr & sb) != (aa & sb));
            end
            2: v = n ^ cur[0];
            default: v = 1'b0;
        endcase
        return {cur[7:4], n, z, v, c};
    endfunction

    task automatic step(bit rst, bit ld, logic [7:0] lv, bit up, int cls,
                        bit wide, int a, int b, int r, string tag);
        rst_n = ~rst; ld_en = ld; ld_val = lv; upd_en = up;
        op_cls = cls[1:0]; wide_sel = wide;
        opa = a[15:0]; opb = b[15:0]; res = r[15:0];
        @(posedge clk);
        exp_ccr = model(exp_ccr, rst, ld, lv, up, cls, wide, a, b, r);
        @(negedge clk);
        n_checks++;
        if (ccr_q !== exp_ccr) begin
            n_fails++;
            $display("FAIL %s ccr actual=%02h expected=%02h", tag, ccr_q, exp_ccr);
        end
        n_checks++;
        if ({flag_n, flag_z, flag_v, flag_c} !== exp_ccr[3:0]) begin
            n_fails++;
            $display("FAIL R11 (%s) flags actual=%b expected=%b", tag,
                     {flag_n, flag_z, flag_v, flag_c}, exp_ccr[3:0]);
        end
    endtask

    task automatic add_op(bit wide, int a, int b, string tag);
        step(0, 0, 8'h00, 1, 0, wide, a, b, a + b, tag);
    endtask

    task automatic sub_op(bit wide, int a, int b, string tag);
        step(0, 0, 8'h00, 1, 1, wide, a, b, a - b, tag);
    endtask

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ld_en = 0; ld_val = 0; upd_en = 0; op_cls = 0;
        wide_sel = 0; opa = 0; opb = 0; res = 0;
        @(negedge clk);
        step(1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 8'hFF, 1, 0, 0, 1, 1, 2, "R1");
        step(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R10");
        // R2 direct loads
        step(0, 1, 8'hA5, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 8'h00, 0, 0, 0, 0, 0, 0, "R2");
        // R3 load beats update
        step(0, 1, 8'h3C, 1, 0, 1, 16'h8000, 16'h8000, 0, "R3");
        // R4 add cases, both sizes
        add_op(0, 8'h7F, 8'h01, "R4");
        add_op(0, 8'hFF, 8'h01, "R4");
        add_op(1, 16'h7FFF, 16'h0001, "R4");
        add_op(1, 16'hFFFF, 16'hFFFF, "R4");
        add_op(1, 16'h8000, 16'h8000, "R4");
        // R5 subtract, borrow and overflow
        sub_op(0, 8'h00, 8'h01, "R5");
        sub_op(0, 8'h80, 8'h01, "R5");
        sub_op(1, 16'h1234, 16'h1234, "R5");
        sub_op(1, 16'h7FFF, 16'hFFFF, "R5");
        // R6 narrow mode ignores upper bits
        step(0, 0, 8'h00, 1, 0, 0, 16'hAB80, 16'hCD80, 16'h5A00, "R6");
        step(0, 0, 8'h00, 1, 3, 0, 0, 0, 16'hFF00, "R6");
        step(0, 0, 8'h00, 1, 3, 1, 0, 0, 16'hFF00, "R6");
        // R7 shift with carry 0 and carry 1 held
        step(0, 1, 8'h01, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 8'h00, 1, 2, 0, 0, 0, 8'h80, "R7");
        step(0, 0, 8'h00, 1, 2, 1, 0, 0, 16'h4000, "R7");
        step(0, 1, 8'h00, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 8'h00, 1, 2, 1, 0, 0, 16'h8000, "R7");
        // R8 test clears V, keeps C
        step(0, 1, 8'h03, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 8'h00, 1, 3, 1, 0, 0, 16'h0000, "R8");
        // R9 upper bits survive updates
        step(0, 1, 8'hF0, 0, 0, 0, 0, 0, 0, "R9");
        add_op(0, 8'hFF, 8'hFF, "R9");
        sub_op(1, 16'h0000, 16'h0001, "R9");
        step(0, 0, 8'h00, 1, 2, 0, 0, 0, 8'h01, "R9");
        // R10 hold with busy inputs
        step(0, 0, 8'h00, 0, 1, 1, 16'hFFFF, 16'h0001, 16'h0000, "R10");
        // Mixed random traffic
        for (int i = 0; i < 300; i++) begin
            int a = $urandom & 32'hFFFF;
            int b = $urandom & 32'hFFFF;
            int cls = $urandom % 4;
            bit wide = $urandom % 2;
            bit ld = ($urandom % 8) == 0;
            bit up = ($urandom % 4) != 0;
            int r = (cls == 0) ? a + b : (cls == 1) ? a - b : ($urandom & 32'hFFFF);
            step(0, ld, 8'($urandom), up, cls, wide, a, b, r, "R4-mix R5-mix R7-mix");
        end
        step(1, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R1");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule